// File: doc/BRIEF.md
# Two-by-two wormhole routing switch

This block is one switching element for a single stage of an inverted n-cube multistage network. It has two inbound links and two outbound links, and each link carries one 9-bit flit per cycle. The low eight bits of a flit are data and bit 8 is a parity bit. Each inbound link feeds its own FIFO. A two-way crossbar connects the heads of the two FIFOs to the two outbound links.

A message is a run of flits with a four-byte header. Byte 0 is the destination address. Byte 1 is the total message length in bytes, header included. Byte 2 is the message type and byte 3 identifies the source. Bytes 2 and 3 pass through without being interpreted.

The switch examines one destination bit, selected by the `STAGE` parameter, to pick the outbound link. It reserves that link for the whole message and holds it until the last byte counted from the length field has left. When both inputs want the same free output in the same cycle, a round-robin arbiter chooses between them. Each outbound link uses a valid/ready handshake, and backpressure reaches each sender through the FIFO's ready signal.

Top module: `wormhole_switch2x2`

## Requirements
- R1: While reset is held and in the first cycle after it, both `outValid` bits are 0, both `inReady` bits are 1 and both `parErr` bits are 0.
- R2: A message leaves on output 0 when bit `STAGE` of its first byte is 0, and on output 1 when that bit is 1.
- R3: Byte 1 of a message gives its total length in bytes. Values below 4 count as 4 and values above 128 count as 128. Exactly that many flits are forwarded under one reservation, and the output is freed after the last of them leaves.
- R4: Once an output is reserved, no flit from the other input reaches it until the reserving message has completed. Two messages bound for different outputs proceed in the same cycles.
- R5: When both inputs are idle and request the same free output in the same cycle, input 0 wins the first such contest after reset. After each contest, the other input has priority in the next contest for that output.
- R6: Every flit leaves with all nine bits unchanged, parity included, and in the order it was accepted.
- R7: While `outValid` is 1 and `outReady` is 0, the output keeps `outValid` at 1 and holds `outFlit` unchanged. An input whose FIFO holds `DEPTH` flits drives `inReady` to 0.
- R8: `parErr[i]` is 1 in the cycle after input i accepts a flit whose nine bits contain an even number of ones, and 0 otherwise. A flagged flit is still forwarded.
- R9: Every accepted flit is delivered exactly once. After the traffic drains, no flit is missing and no flit is extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 2 | Flit offered on each inbound link |
| inFlit | input | 2x9 | Inbound flits: bit 8 is parity, bits 7:0 are data |
| inReady | output | 2 | Inbound FIFO has room |
| outValid | output | 2 | Flit presented on each outbound link |
| outFlit | output | 2x9 | Outbound flits |
| outReady | input | 2 | Downstream accepts the flit on each outbound link |
| parErr | output | 2 | One-cycle pulse when a flit accepted on that input had even parity |

## Verification
Two equal-time headers aimed at the same output are sent twice in a row. A design with fixed priority, or one that rotates on every grant, would deliver the second pair in the wrong order.

A long message with gaps is interleaved with a short request from the other input to the same output. An early release or a missing hold would splice bytes from the two messages, and the per-message comparison would catch that.

Length bytes below 4 and above 128 test the clamp. A wrong counter would cut a message short or swallow the next header.

Randomly stalled outputs and a filled FIFO test hold stability and `inReady`. Flits with bad parity test the error pulse and show that the flit still passes unchanged.

// File: rtl/wsw_pkg.sv
package wsw_pkg;
  localparam int FLIT_W = 9;
  typedef logic [FLIT_W-1:0] flit_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] pop;     // dequeue head of input FIFO i
    logic [1:0] outEn;   // output o is reserved
    logic [1:0] outSrc;  // input that owns output o
  } xbarCtl_t;
endpackage

// File: rtl/wsw_fifo.sv
module wsw_fifo import wsw_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  flit_t pushData,
  input  logic  pop,
  output flit_t popData,
  output logic  empty,
  output logic  full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  flit_t mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;

  assign empty = (count == '0);
  assign full = (count == CNT_FULL);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7
  fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
endmodule

// File: rtl/wsw_datapath.sv
module wsw_datapath import wsw_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      inValid,
  input  flit_t [1:0]     inFlit,
  output logic [1:0]      inReady,
  input  xbarCtl_t        ctl,
  output logic [1:0]      fifoEmpty,
  output flit_t [1:0]     headFlit,
  output logic [1:0]      outValid,
  output flit_t [1:0]     outFlit,
  output logic [1:0]      parErr
);
  logic [1:0] full, push;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_in
      assign push[i] = inValid[i] && !full[i];
      assign inReady[i] = !full[i];
      wsw_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push[i]), .pushData(inFlit[i]),
        .pop(ctl.pop[i]), .popData(headFlit[i]),
        .empty(fifoEmpty[i]), .full(full[i])
      );
      // R8
      parerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parErr[i] |-> $past(inValid[i] && inReady[i]));
    end
  endgenerate

  // odd parity over nine bits is the legal case
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parErr <= '0;
    else for (int i = 0; i < 2; i++) parErr[i] <= push[i] && !(^inFlit[i]);
  end

  // crossbar: each output shows the head of its owning input
  always_comb begin
    for (int o = 0; o < 2; o++) begin
      outFlit[o] = headFlit[ctl.outSrc[o]];
      outValid[o] = ctl.outEn[o] && !fifoEmpty[ctl.outSrc[o]];
    end
  end
endmodule

// File: rtl/wsw_ctrl.sv
module wsw_ctrl import wsw_pkg::*; #(
  parameter int STAGE   = 2,
  parameter int MAX_LEN = 128,
  parameter int HDR_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fifoEmpty,
  input  flit_t [1:0] headFlit,
  input  logic [1:0]  outReady,
  output xbarCtl_t    ctl
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] LEN_POS = CW'(1);   // index of the size byte
  localparam logic [CW-1:0] LEN_LO = CW'(HDR_LEN);
  localparam logic [CW-1:0] LEN_HI = CW'(MAX_LEN);

  logic [1:0] busy, route, owned, owner, prio;
  logic [CW-1:0] idx [2];
  logic [CW-1:0] lenQ [2];
  logic [1:0] req, want, lastByte, pop, fire, contested, winner, anyGrant, grantIn;

  function automatic logic [CW-1:0] clampLen(input logic [7:0] b);
    int v;
    v = int'(b);
    if (v < HDR_LEN) return LEN_LO;
    if (v > MAX_LEN) return LEN_HI;
    return CW'(v);
  endfunction

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      req[i] = !busy[i] && !fifoEmpty[i];
      want[i] = headFlit[i][STAGE];
      lastByte[i] = (idx[i] > LEN_POS) && ((idx[i] + CW'(1)) == lenQ[i]);
    end
    for (int o = 0; o < 2; o++) begin
      logic c0, c1;
      c0 = req[0] && (want[0] == 1'(o)) && !owned[o];
      c1 = req[1] && (want[1] == 1'(o)) && !owned[o];
      contested[o] = c0 && c1;
      anyGrant[o] = c0 || c1;
      winner[o] = contested[o] ? prio[o] : c1;
      fire[o] = owned[o] && !fifoEmpty[owner[o]] && outReady[o];
    end
    for (int i = 0; i < 2; i++) begin
      pop[i] = (fire[0] && owner[0] == 1'(i)) || (fire[1] && owner[1] == 1'(i));
      grantIn[i] = (anyGrant[0] && winner[0] == 1'(i)) ||
                   (anyGrant[1] && winner[1] == 1'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      route <= '0;
      owned <= '0;
      owner <= '0;
      prio <= '0;
      for (int i = 0; i < 2; i++) begin
        idx[i] <= '0;
        lenQ[i] <= LEN_LO;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (grantIn[i]) begin
          busy[i] <= 1'b1;
          route[i] <= want[i];
          idx[i] <= '0;
        end else if (pop[i]) begin
          idx[i] <= idx[i] + CW'(1);
          if (idx[i] == LEN_POS) lenQ[i] <= clampLen(headFlit[i][7:0]);
          if (lastByte[i]) busy[i] <= 1'b0;
        end
      end
      for (int o = 0; o < 2; o++) begin
        if (anyGrant[o]) begin
          owned[o] <= 1'b1;
          owner[o] <= winner[o];
          if (contested[o]) prio[o] <= !winner[o];
        end else if (fire[o] && lastByte[owner[o]]) begin
          owned[o] <= 1'b0;
        end
      end
    end
  end

  assign ctl.pop = pop;
  assign ctl.outEn = owned;
  assign ctl.outSrc = owner;

  // R4
  owner_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned == 2'b11) |-> (owner[0] != owner[1]));

  generate
    for (genvar g = 0; g < 2; g++) begin : g_chk
      // R4
      hold_until_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned[g] && !fire[g]) |=> (owned[g] && $stable(owner[g])));
      // R3
      busy_has_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] |-> (owned[route[g]] && owner[route[g]] == 1'(g)));
      // R3
      length_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] |-> (idx[g] < LEN_HI));
    end
  endgenerate
endmodule

// File: rtl/wormhole_switch2x2.sv
module wormhole_switch2x2 import wsw_pkg::*; #(
  parameter int STAGE   = 2,
  parameter int DEPTH   = 4,
  parameter int MAX_LEN = 128,
  parameter int HDR_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      inValid,
  input  logic [1:0][8:0] inFlit,
  output logic [1:0]      inReady,
  output logic [1:0]      outValid,
  output logic [1:0][8:0] outFlit,
  input  logic [1:0]      outReady,
  output logic [1:0]      parErr
);
  xbarCtl_t ctl;
  logic [1:0] fifoEmpty;
  flit_t [1:0] headFlit;

  wsw_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inFlit(inFlit), .inReady(inReady),
    .ctl(ctl), .fifoEmpty(fifoEmpty), .headFlit(headFlit),
    .outValid(outValid), .outFlit(outFlit), .parErr(parErr)
  );

  wsw_ctrl #(.STAGE(STAGE), .MAX_LEN(MAX_LEN), .HDR_LEN(HDR_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fifoEmpty(fifoEmpty), .headFlit(headFlit),
    .outReady(outReady), .ctl(ctl)
  );

  generate
    for (genvar o = 0; o < 2; o++) begin : g_out
      // R7
      stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outValid[o] && !outReady[o]) |=> (outValid[o] && $stable(outFlit[o])));
    end
  endgenerate
endmodule

// File: tb/tb_wormhole_switch2x2.sv
module tb_wormhole_switch2x2;
  localparam int CLK_PERIOD = 10;
  localparam int STG = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] inValid = '0;
  logic [1:0][8:0] inFlit = '0;
  logic [1:0] inReady, outValid, parErr;
  logic [1:0][8:0] outFlit;
  logic [1:0] outReady = '0;

  wormhole_switch2x2 #(.STAGE(STG), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFlit(inFlit),
    .inReady(inReady), .outValid(outValid), .outFlit(outFlit),
    .outReady(outReady), .parErr(parErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int readyMode = 0;
  int acceptCnt [2];
  int errSeen = 0;
  int seqCnt [2];
  bit bothSeen = 0;
  bit done = 0;
  bit expErr [2];
  bit prevStall [2];
  logic [8:0] prevFlit [2];
  logic [8:0] expQ [0:3][$];
  logic [8:0] rxBuf [0:1][$];
  int orderLog [0:1][$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampLen(input int b);
    if (b < 4) return 4;
    if (b > 128) return 128;
    return b;
  endfunction

  function automatic logic [8:0] mkFlit(input logic [7:0] d, input bit bad);
    return {(~^d) ^ bad, d};
  endfunction

  task automatic sendMsg(input int src, input int dst, input int lenByte,
                         input int gapMax, input int badMod);
    int n;
    logic [8:0] f [$];
    logic [7:0] d;
    bit bad;
    bit acc;
    n = clampLen(lenByte);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      if (k == 0) d[STG] = dst[0];
      if (k == 1) d = 8'(lenByte);
      if (k == 3) d = {7'(seqCnt[src]), src[0]};
      bad = (badMod > 0) && (($urandom % badMod) == 0);
      f.push_back(mkFlit(d, bad));
    end
    seqCnt[src]++;
    foreach (f[k]) expQ[src*2+dst].push_back(f[k]);
    foreach (f[k]) begin
      inFlit[src] = f[k];
      inValid[src] = 1'b1;
      do begin
        @(negedge clk);
        acc = inReady[src];
        @(posedge clk);
        #1;
      end while (!acc);
      inValid[src] = 1'b0;
      if (gapMax > 0) repeat ($urandom % (gapMax + 1)) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic finishMsg(input int o);
    int src, n, k;
    bit ok;
    int badAct, badExp;
    logic [8:0] e;
    ok = 1;
    badAct = 0;
    badExp = 0;
    n = rxBuf[o].size();
    src = int'(rxBuf[o][3][0]);
    // R2 routing bit
    check(rxBuf[o][0][STG] == o[0], "R2 route", int'(rxBuf[o][0][STG]), o);
    if (expQ[src*2+o].size() < n) begin
      ok = 0;
      badAct = n;
      badExp = expQ[src*2+o].size();
    end else begin
      for (k = 0; k < n; k++) begin
        e = expQ[src*2+o].pop_front();
        if (e !== rxBuf[o][k] && ok) begin
          ok = 0;
          badAct = int'(rxBuf[o][k]);
          badExp = int'(e);
        end
      end
    end
    // R3 R6 R9 content, length and order of one whole message
    check(ok, "R6 message content", badAct, badExp);
    orderLog[o].push_back(src);
    rxBuf[o].delete();
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      expErr[0] = 0;
      expErr[1] = 0;
      prevStall[0] = 0;
      prevStall[1] = 0;
    end else begin
      if (outValid == 2'b11) bothSeen = 1;
      for (int o = 0; o < 2; o++) begin
        if (prevStall[o])
          check(outValid[o] && outFlit[o] == prevFlit[o], "R7 stall hold",
                int'(outFlit[o]), int'(prevFlit[o]));
        prevStall[o] = outValid[o] && !outReady[o];
        prevFlit[o] = outFlit[o];
        if (outValid[o] && outReady[o]) begin
          rxBuf[o].push_back(outFlit[o]);
          if (rxBuf[o].size() >= 2 &&
              rxBuf[o].size() == clampLen(int'(rxBuf[o][1][7:0])))
            finishMsg(o);
        end
      end
      for (int i = 0; i < 2; i++) begin
        // R8 error pulse follows acceptance of an even-parity flit
        check(parErr[i] == expErr[i], "R8 parity flag", int'(parErr[i]), int'(expErr[i]));
        if (parErr[i]) errSeen++;
        expErr[i] = inValid[i] && inReady[i] && !(^inFlit[i]);
        if (inValid[i] && inReady[i]) acceptCnt[i]++;
      end
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    case (readyMode)
      0: outReady = 2'b00;
      1: outReady = 2'b11;
      default: outReady = {(($urandom % 4) != 0), (($urandom % 4) != 0)};
    endcase
  end

  task automatic drain();
    int t;
    t = 0;
    while ((expQ[0].size() + expQ[1].size() + expQ[2].size() + expQ[3].size()) != 0
           && t < 4000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic randTraffic(input int src, input int count);
    int lb;
    for (int m = 0; m < count; m++) begin
      lb = (($urandom % 10) == 0) ? int'($urandom % 4) : 4 + int'($urandom % 21);
      sendMsg(src, int'($urandom % 2), lb, 2, 8);
    end
  endtask

  initial begin
    int base, baseAcc;
    void'($urandom(32'h1234abcd));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(outValid == 2'b00, "R1 outValid", int'(outValid), 0);
    check(inReady == 2'b11, "R1 inReady", int'(inReady), 3);
    check(parErr == 2'b00, "R1 parErr", int'(parErr), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 2'b00 && inReady == 2'b11, "R1 after release",
          int'({outValid, inReady}), 3);
    @(posedge clk);
    #1;

    // R5 two contests for output 0: input 0 first, then input 1
    readyMode = 1;
    fork
      sendMsg(0, 0, 6, 0, 0);
      sendMsg(1, 0, 6, 0, 0);
    join
    drain();
    fork
      sendMsg(0, 0, 5, 0, 0);
      sendMsg(1, 0, 5, 0, 0);
    join
    drain();
    check(orderLog[0].size() == 4, "R5 message count", orderLog[0].size(), 4);
    if (orderLog[0].size() == 4) begin
      check(orderLog[0][0] == 0, "R5 first contest", orderLog[0][0], 0);
      check(orderLog[0][1] == 1, "R5 first loser", orderLog[0][1], 1);
      check(orderLog[0][2] == 1, "R5 second contest", orderLog[0][2], 1);
      check(orderLog[0][3] == 0, "R5 second loser", orderLog[0][3], 0);
    end

    // R4 different outputs run in parallel
    bothSeen = 0;
    fork
      sendMsg(0, 0, 20, 0, 0);
      sendMsg(1, 1, 20, 0, 0);
    join
    drain();
    check(bothSeen, "R4 concurrent outputs", int'(bothSeen), 1);

    // R4 R3 reservation held through gaps; short (clamped) message waits
    base = orderLog[0].size();
    fork
      sendMsg(0, 0, 40, 3, 0);
      begin
        repeat (3) @(posedge clk);
        #1;
        sendMsg(1, 0, 2, 0, 0);
      end
    join
    drain();
    check(orderLog[0].size() == base + 2, "R4 held count", orderLog[0].size(), base + 2);
    if (orderLog[0].size() == base + 2) begin
      check(orderLog[0][base] == 0, "R4 owner first", orderLog[0][base], 0);
      check(orderLog[0][base+1] == 1, "R4 waiter second", orderLog[0][base+1], 1);
    end

    // R3 oversize length clamps to 128 and the next message follows intact
    base = orderLog[1].size();
    sendMsg(1, 1, 200, 0, 0);
    sendMsg(1, 1, 4, 0, 0);
    drain();
    check(orderLog[1].size() == base + 2, "R3 clamp high", orderLog[1].size(), base + 2);

    // R7 FIFO fills to DEPTH under a stalled output
    baseAcc = acceptCnt[0];
    readyMode = 0;
    fork
      sendMsg(0, 1, 10, 0, 0);
      begin
        repeat (DEPTH + 8) @(negedge clk);
        check(inReady[0] == 1'b0, "R7 inReady when full", int'(inReady[0]), 0);
        check(acceptCnt[0] - baseAcc == DEPTH, "R7 accepted depth",
              acceptCnt[0] - baseAcc, DEPTH);
        check(outValid[1] == 1'b1, "R7 stalled valid", int'(outValid[1]), 1);
        readyMode = 1;
      end
    join
    drain();

    // R8 a message with every flit bad still passes unchanged
    base = errSeen;
    sendMsg(0, 1, 6, 0, 1);
    drain();
    check(errSeen - base == 6, "R8 error pulses", errSeen - base, 6);

    // random mix with backpressure
    readyMode = 2;
    fork
      randTraffic(0, 30);
      randTraffic(1, 30);
    join
    drain();

    // R9 nothing left over
    for (int q = 0; q < 4; q++)
      check(expQ[q].size() == 0, "R9 undelivered flits", expQ[q].size(), 0);
    check(rxBuf[0].size() == 0 && rxBuf[1].size() == 0, "R9 partial message",
          rxBuf[0].size() + rxBuf[1].size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule